// File: doc/BRIEF.md
# Shared-Rail Regulator Mode Arbiter

Several cores draw from one input supply rail, and each core asks for its own supply voltage as a 10-bit millivolt code. This block collects one set of those requests on a start pulse and works out three things. First, the rail voltage to ask of the external power manager. Second, for each core, whether it connects straight to the rail through its head switch or runs behind its low-dropout regulator. Third, the regulator reference code for each core that uses its regulator.

The rail request is the highest target among the cores flagged valid. A core can use its regulator only inside the regulator's working window. Its target must sit more than a programmable dropout below the rail, and the rail itself must be at or above a programmable minimum input level. A core outside that window falls back to bypass and runs at the rail voltage. A core flagged invalid is left out of the maximum and gets neither bypass nor regulator enable. The results are registered and marked by a one-cycle done strobe, and they hold until the next start.

Top module: `rail_mode_arbiter`

## Requirements
- R1: After a computation, `rail_code` equals the largest `core_target` among the cores whose `core_valid` bit was 1 at start; it is 0 when no core was valid.
- R2: A valid core whose target equals the rail request has `sw_bypass` = 1 and `reg_enable` = 0, including when several cores tie at the maximum.
- R3: A valid core gets `reg_enable` = 1 only when target + dropout < rail request (strict); otherwise it gets `sw_bypass` = 1. With rail 950, dropout 150: a target of 850 or 800 bypasses, a target of 799 regulates.
- R4: When the rail request is below the minimum rail setting, every valid core has `sw_bypass` = 1 and no core has `reg_enable` = 1.
- R5: A core with `reg_enable` = 1 has its slice of `reg_ref` equal to its target; any other core has a slice of 0. Core i owns bits [10*i+9 : 10*i] of `core_target` and `reg_ref`.
- R6: A core with `core_valid` = 0 gets `sw_bypass` = 0, `reg_enable` = 0 and a reference of 0, and its target does not affect `rail_code`.
- R7: Inputs are captured at the clock edge where `start` is 1. The results and a one-cycle `done` appear one edge later. Input changes without `start` do not change any output.
- R8: No core ever has `sw_bypass` and `reg_enable` both 1.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the request set on this edge |
| core_valid | input | NUM_CORES | Per-core active flag |
| core_target | input | NUM_CORES*10 | Per-core target voltage codes in mV, core i at bits [10*i+9:10*i] |
| cfg_dropout | input | 10 | Regulator dropout headroom in mV |
| cfg_min_rail | input | 10 | Lowest rail voltage at which regulators may run, in mV |
| rail_code | output | 10 | Rail voltage request to the power manager, in mV |
| sw_bypass | output | NUM_CORES | Per-core head switch close |
| reg_enable | output | NUM_CORES | Per-core regulator engage |
| reg_ref | output | NUM_CORES*10 | Per-core regulator reference codes |
| done | output | 1 | One-cycle strobe marking new results |

## Verification
The request set is captured at the edge where `start` is high. The rail code, bypass and enable bits, references and `done` all change together at the following edge, and they stay fixed until a later start has gone through the same two edges. The bench model captures the inputs at the same start edge, stages them for one cycle, and then publishes its expected outputs. The bench compares every output at each falling edge, so the comparison always sees values that settled at the preceding rising edge. Stretches with no start, including ones where the inputs change, are therefore checked every cycle against the held values.

// File: rtl/rail_arb_pkg.sv
package rail_arb_pkg;

    localparam int MV_W = 10;

    typedef logic [MV_W-1:0] mv_t;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_BYPASS   = 2'd1,
        MODE_REGULATE = 2'd2
    } core_mode_e;

    typedef struct packed {
        core_mode_e mode;
        mv_t        ref_code;
    } core_res_t;

    // True when the target leaves more than the dropout headroom under the rail.
    function automatic logic window_ok(mv_t target, mv_t rail, mv_t dropout);
        logic [MV_W:0] need;
        need = {1'b0, target} + {1'b0, dropout};
        return need < {1'b0, rail};
    endfunction

endpackage

// File: rtl/rail_max_select.sv
module rail_max_select
    import rail_arb_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] valid,
    input  mv_t                  target [NUM_CORES],
    output mv_t                  rail
);

    always_comb begin
        rail = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (valid[i] && (target[i] > rail)) begin
                rail = target[i];
            end
        end
    end

endmodule

// File: rtl/core_mode_decide.sv
module core_mode_decide
    import rail_arb_pkg::*;
(
    input  logic      valid,
    input  mv_t       target,
    input  mv_t       rail,
    input  mv_t       dropout,
    input  mv_t       min_rail,
    output core_res_t result
);

    logic rail_low;
    logic at_rail;
    logic fits;

    assign rail_low = rail < min_rail;
    assign at_rail  = target == rail;
    assign fits     = window_ok(target, rail, dropout);

    always_comb begin
        result.mode     = MODE_OFF;
        result.ref_code = '0;
        if (valid) begin
            if (rail_low || at_rail || !fits) begin
                result.mode = MODE_BYPASS;
            end else begin
                result.mode     = MODE_REGULATE;
                result.ref_code = target;
            end
        end
    end

endmodule

// File: rtl/rail_mode_arbiter.sv
module rail_mode_arbiter
    import rail_arb_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [NUM_CORES-1:0]      core_valid,
    input  logic [NUM_CORES*MV_W-1:0] core_target,
    input  logic [MV_W-1:0]           cfg_dropout,
    input  logic [MV_W-1:0]           cfg_min_rail,
    output logic [MV_W-1:0]           rail_code,
    output logic [NUM_CORES-1:0]      sw_bypass,
    output logic [NUM_CORES-1:0]      reg_enable,
    output logic [NUM_CORES*MV_W-1:0] reg_ref,
    output logic                      done
);

    // Captured request set
    logic                 pending_q;
    logic [NUM_CORES-1:0] vld_q;
    mv_t                  tgt_q [NUM_CORES];
    mv_t                  drop_q;
    mv_t                  min_q;

    // Combinational results
    mv_t       rail_w;
    core_res_t res_w [NUM_CORES];

    // Result registers
    mv_t                  rail_q;
    logic [NUM_CORES-1:0] byp_q;
    logic [NUM_CORES-1:0] en_q;
    mv_t                  ref_q [NUM_CORES];
    logic                 done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            vld_q     <= '0;
            drop_q    <= '0;
            min_q     <= '0;
            for (int i = 0; i < NUM_CORES; i++) begin
                tgt_q[i] <= '0;
            end
        end else begin
            pending_q <= start;
            if (start) begin
                vld_q  <= core_valid;
                drop_q <= cfg_dropout;
                min_q  <= cfg_min_rail;
                for (int i = 0; i < NUM_CORES; i++) begin
                    tgt_q[i] <= core_target[i*MV_W +: MV_W];
                end
            end
        end
    end

    rail_max_select #(.NUM_CORES(NUM_CORES)) u_max (
        .valid  (vld_q),
        .target (tgt_q),
        .rail   (rail_w)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        core_mode_decide u_dec (
            .valid    (vld_q[g]),
            .target   (tgt_q[g]),
            .rail     (rail_w),
            .dropout  (drop_q),
            .min_rail (min_q),
            .result   (res_w[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                byp_q[g] <= 1'b0;
                en_q[g]  <= 1'b0;
                ref_q[g] <= '0;
            end else if (pending_q) begin
                byp_q[g] <= res_w[g].mode == MODE_BYPASS;
                en_q[g]  <= res_w[g].mode == MODE_REGULATE;
                ref_q[g] <= res_w[g].ref_code;
            end
        end

        assign reg_ref[g*MV_W +: MV_W] = ref_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= pending_q;
            if (pending_q) begin
                rail_q <= rail_w;
            end
        end
    end

    assign rail_code  = rail_q;
    assign sw_bypass  = byp_q;
    assign reg_enable = en_q;
    assign done       = done_q;

endmodule

// File: rtl/rail_mode_arbiter_chk.sv
module rail_mode_arbiter_chk
    import rail_arb_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [MV_W-1:0]           rail_code,
    input logic [NUM_CORES-1:0]      sw_bypass,
    input logic [NUM_CORES-1:0]      reg_enable,
    input logic [NUM_CORES*MV_W-1:0] reg_ref,
    input logic                      done,
    input logic [MV_W-1:0]           lat_min
);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(|(sw_bypass & reg_enable)));

    assert_done_timing_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> ##1 done);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rail_code) && $stable(sw_bypass)
                   && $stable(reg_enable) && $stable(reg_ref)));

    assert_min_rail_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(start) && (|reg_enable)) |-> (rail_code >= lat_min));

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        assert_ref_below_R3: assert property (@(posedge clk) disable iff (rst)
            reg_enable[g] |-> (reg_ref[g*MV_W +: MV_W] < rail_code));

        assert_ref_zero_R5: assert property (@(posedge clk) disable iff (rst)
            !reg_enable[g] |-> (reg_ref[g*MV_W +: MV_W] == '0));
    end

endmodule

bind rail_mode_arbiter rail_mode_arbiter_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rail_code  (rail_code),
    .sw_bypass  (sw_bypass),
    .reg_enable (reg_enable),
    .reg_ref    (reg_ref),
    .done       (done),
    .lat_min    (min_q)
);

// File: tb/rail_mode_arbiter_tb.sv
`timescale 1ns/1ps
module rail_mode_arbiter_tb;

    localparam int N = 4;
    localparam int W = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   core_valid = '0;
    logic [N*W-1:0] core_target = '0;
    logic [W-1:0]   cfg_dropout = '0;
    logic [W-1:0]   cfg_min_rail = '0;
    logic [W-1:0]   rail_code;
    logic [N-1:0]   sw_bypass;
    logic [N-1:0]   reg_enable;
    logic [N*W-1:0] reg_ref;
    logic           done;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    rail_mode_arbiter #(.NUM_CORES(N)) u_dut (
        .clk(clk), .rst(rst), .start(start), .core_valid(core_valid),
        .core_target(core_target), .cfg_dropout(cfg_dropout),
        .cfg_min_rail(cfg_min_rail), .rail_code(rail_code),
        .sw_bypass(sw_bypass), .reg_enable(reg_enable),
        .reg_ref(reg_ref), .done(done)
    );

    // Behavioural reference model
    int       m_rail, p_rail;
    bit [N-1:0] m_byp, m_en, p_byp, p_en;
    int       m_ref[N], p_ref[N];
    bit       m_done, m_pend;

    always @(posedge clk) begin
        if (rst) begin
            m_rail = 0; m_byp = '0; m_en = '0; m_done = 0; m_pend = 0;
            for (int i = 0; i < N; i++) m_ref[i] = 0;
        end else begin
            if (m_pend) begin
                m_rail = p_rail; m_byp = p_byp; m_en = p_en;
                for (int i = 0; i < N; i++) m_ref[i] = p_ref[i];
            end
            m_done = m_pend;
            m_pend = start;
            if (start) begin
                int t[N];
                p_rail = 0;
                for (int i = 0; i < N; i++) begin
                    t[i] = int'(core_target[i*W +: W]);
                    if (core_valid[i] && t[i] > p_rail) p_rail = t[i];
                end
                for (int i = 0; i < N; i++) begin
                    p_byp[i] = 0; p_en[i] = 0; p_ref[i] = 0;
                    if (core_valid[i]) begin
                        if (p_rail >= int'(cfg_min_rail) && t[i] != p_rail
                            && t[i] + int'(cfg_dropout) < p_rail) begin
                            p_en[i] = 1; p_ref[i] = t[i];
                        end else begin
                            p_byp[i] = 1;
                        end
                    end
                end
            end
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            bit bad;
            bad = 0;
            vectors++;
            if (int'(rail_code) != m_rail) begin
                bad = 1;
                $display("FAIL R1 rail_code act=%0d exp=%0d", rail_code, m_rail);
            end
            if (sw_bypass != m_byp) begin
                bad = 1;
                $display("FAIL R2/R3/R4/R6 sw_bypass act=%b exp=%b", sw_bypass, m_byp);
            end
            if (reg_enable != m_en) begin
                bad = 1;
                $display("FAIL R3 reg_enable act=%b exp=%b", reg_enable, m_en);
            end
            for (int i = 0; i < N; i++) begin
                if (int'(reg_ref[i*W +: W]) != m_ref[i]) begin
                    bad = 1;
                    $display("FAIL R5 reg_ref[%0d] act=%0d exp=%0d", i,
                             reg_ref[i*W +: W], m_ref[i]);
                end
            end
            if (done != m_done) begin
                bad = 1;
                $display("FAIL R7 done act=%b exp=%b", done, m_done);
            end
            if (|(sw_bypass & reg_enable)) begin
                bad = 1;
                $display("FAIL R8 overlap act=%b exp=0", sw_bypass & reg_enable);
            end
            if (bad) miscompares++;
        end
    end

    task automatic run_set(input logic [N-1:0] v, input int t0, input int t1,
                           input int t2, input int t3, input int drop, input int mn);
        @(negedge clk);
        core_valid   = v;
        core_target  = {W'(t3), W'(t2), W'(t1), W'(t0)};
        cfg_dropout  = W'(drop);
        cfg_min_rail = W'(mn);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_on = 1'b1;          // R9: reset values compared here
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 R2 R3: mixed targets, rail 950
        run_set(4'b1111, 950, 850, 700, 500, 150, 400);
        // R3 boundary: 800 bypasses, 799 regulates
        run_set(4'b1111, 950, 800, 799, 600, 150, 400);
        // R2: tie at the maximum
        run_set(4'b1111, 900, 900, 600, 300, 100, 400);
        // R4: rail below minimum, all bypass
        run_set(4'b0111, 550, 400, 300, 1000, 50, 600);
        // R6: invalid core with the highest target excluded
        run_set(4'b0101, 700, 1020, 500, 990, 100, 400);
        // R1 R6: no valid cores
        run_set(4'b0000, 700, 800, 900, 600, 100, 0);
        // R4 boundary: rail equal to minimum still regulates
        run_set(4'b0011, 600, 400, 0, 0, 100, 600);
        // R7: inputs change without start, outputs hold
        @(negedge clk);
        core_valid = 4'b1111; core_target = '1; cfg_dropout = '0;
        repeat (5) @(negedge clk);
        // R7: back-to-back starts
        @(negedge clk);
        core_valid = 4'b1111; core_target = {10'd300, 10'd400, 10'd500, 10'd600};
        cfg_dropout = 10'd50; cfg_min_rail = 10'd100;
        start = 1'b1;
        @(negedge clk);
        core_target = {10'd900, 10'd890, 10'd700, 10'd200};
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        // Mixed patterns
        for (int k = 0; k < 60; k++) begin
            run_set(N'($urandom), 300 + int'($urandom_range(0, 720)),
                    300 + int'($urandom_range(0, 720)), 300 + int'($urandom_range(0, 720)),
                    300 + int'($urandom_range(0, 720)), int'($urandom_range(0, 300)),
                    int'($urandom_range(0, 900)));
        end
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule